// File: doc/BRIEF.md
# Byte-Wide Erasable ROM Pin-Mode Controller

This block models a byte-organised, erasable read-only memory together with the logic that turns its control pins into an operating mode. The chip-enable pin, the shared output-enable/program-supply pin and a high-voltage marker on one address line are decoded into these modes: array read, output disable, standby, program, program inhibit and identifier read. Each drives or releases an 8-bit output bus. A tri-state enable is reported beside the bus, so the enclosing chip can place the drivers. Analog levels are reduced to flags. `vpp_hi` says the shared pin is at programming voltage, and `sig_hv` says the identifier voltage is present on the marked address line.

Programming follows the rules of a floating-gate array. A byte is written when chip enable rises at the end of a low pulse, and the supply pin must sit at programming voltage for the whole of that pulse. The stored value becomes the old byte ANDed with the input byte, so a write can clear bits but never set them. Only the `erase` input returns the array to all ones. A sticky fault flag records any attempt to raise programming voltage while the main supply is reported absent.

The array depth is `2**ADDR_W` bytes. The default of 10 keeps elaboration small, and 16 gives the full 64K-byte organisation. All pins are sampled on `clk`. Read data and the output enable follow the pins combinationally.

Top module: `uvrom_core`

## Requirements
- R1: After reset, and in the cycle after `erase` is sampled high, every byte of the array reads 0xFF.
- R2: When `ce_n` rises after a low phase during which `vpp_hi` was 1 on every sampled cycle, and `vpp_hi` is still 1 on the rising cycle, the byte at `addr` becomes its old value AND `din`. No bit ever changes from 0 to 1 except through R1.
- R3: A low phase of `ce_n` in which `vpp_hi` is 0 on any sampled cycle writes nothing. This includes the case of the pin dropping to a logic-low output enable in the middle of the pulse.
- R4: With `ce_n`=0, `vpp_hi`=0, `oe_vpp_n`=0 and `sig_hv`=0, `dout_en` is 1 and `dout` equals the stored byte at `addr`.
- R5: With `ce_n`=0, `vpp_hi`=0 and `oe_vpp_n`=1, `dout_en` is 0 and `dout` is 0x00.
- R6: With `ce_n`=1, `dout_en` is 0 and `dout` is 0x00, whatever the levels of `oe_vpp_n`, `vpp_hi` and `sig_hv`.
- R7: While `vpp_hi`=1 the outputs stay off (`dout_en`=0, `dout`=0x00). With `ce_n` held at 1, activity on `addr` and `din` changes no stored byte (program inhibit).
- R8: With `ce_n`=0, `vpp_hi`=0, `oe_vpp_n`=0 and `sig_hv`=1, `dout_en` is 1 and `dout` is 0x20 when `addr[0]`=0, or 0x3D when `addr[0]`=1.
- R9: `seq_err` goes to 1 in the cycle after `vpp_hi`=1 is sampled together with `vcc_ok`=0. Once set, it stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Active-low chip enable; its rising edge ends a program pulse |
| oe_vpp_n | input | 1 | Logic level of the shared output-enable/supply pin, active low |
| vpp_hi | input | 1 | Shared pin is at programming voltage |
| sig_hv | input | 1 | Identifier voltage present on the marked address line |
| vcc_ok | input | 1 | Main supply reported present |
| din | input | 8 | Byte to program |
| erase | input | 1 | Return the whole array to all ones |
| dout | output | 8 | Read or identifier byte, 0x00 when released |
| dout_en | output | 1 | Output drivers enabled |
| seq_err | output | 1 | Sticky supply-sequence fault |

## Verification
The mode decode is driven over every combination that selects a distinct mode, on an erased array. This shows whether each pin combination drives array data, identifier codes or nothing, including standby and inhibit with the output-enable level low. Programming is tried with a byte that clears some bits, then with a byte that would set cleared bits, then with 0xFF. This separates an AND update from a plain overwrite. A pulse that loses programming voltage in the middle, an inhibited address and data sweep, and a program at the top address show whether writes land only where a valid pulse says. A final erase and a supply-order violation cover the restore path and the sticky fault.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] ID_MAKER  = 8'h20;
  localparam logic [DATA_W-1:0] ID_DEVICE = 8'h3D;

  typedef enum logic [2:0] {
    PM_STANDBY,
    PM_INHIBIT,
    PM_PROGRAM,
    PM_OFF,
    PM_READ,
    PM_IDENT
  } pin_mode_e;
endpackage

// File: rtl/uvrom_rst_sync.sv
module uvrom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
  import uvrom_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      sig_hv,
  output pin_mode_e mode
);
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? PM_INHIBIT : PM_STANDBY;
    end else if (vpp_hi) begin
      mode = PM_PROGRAM;
    end else if (oe_n) begin
      mode = PM_OFF;
    end else begin
      mode = sig_hv ? PM_IDENT : PM_READ;
    end
  end
endmodule

// File: rtl/uvrom_prog_ctl.sv
module uvrom_prog_ctl (
  input  logic clk,
  input  logic rst_s,
  input  logic ce_n,
  input  logic vpp_hi,
  output logic wr_en
);
  // ce_q: chip enable seen last cycle; arm_q: current low phase has held vpp throughout
  logic ce_q, ce_d;
  logic arm_q, arm_d;

  always_comb begin
    ce_d = ce_n;
    if (ce_n)      arm_d = 1'b0;
    else if (ce_q) arm_d = vpp_hi;
    else           arm_d = arm_q & vpp_hi;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ce_q  <= 1'b1;
      arm_q <= 1'b0;
    end else begin
      ce_q  <= ce_d;
      arm_q <= arm_d;
    end
  end

  assign wr_en = ce_n & ~ce_q & arm_q & vpp_hi;
endmodule

// File: rtl/uvrom_array.sv
module uvrom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = cells[addr] & wr_data;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= merged;
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/uvrom_core.sv
module uvrom_core
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_vpp_n,
  input  logic              vpp_hi,
  input  logic              sig_hv,
  input  logic              vcc_ok,
  input  logic [DATA_W-1:0] din,
  input  logic              erase,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              seq_err
);
  logic              rst_s;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data;
  pin_mode_e         mode;
  logic              err_q, err_d, err_set;

  uvrom_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  uvrom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_vpp_n),
    .vpp_hi (vpp_hi),
    .sig_hv (sig_hv),
    .mode   (mode)
  );

  uvrom_prog_ctl u_prog (
    .clk    (clk),
    .rst_s  (rst_s),
    .ce_n   (ce_n),
    .vpp_hi (vpp_hi),
    .wr_en  (wr_en)
  );

  uvrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_s   (rst_s),
    .erase   (erase),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (din),
    .rd_data (rd_data)
  );

  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    case (mode)
      PM_READ: begin
        dout    = rd_data;
        dout_en = 1'b1;
      end
      PM_IDENT: begin
        dout    = addr[0] ? ID_DEVICE : ID_MAKER;
        dout_en = 1'b1;
      end
      default: begin
        dout    = '0;
        dout_en = 1'b0;
      end
    endcase
  end

  always_comb begin
    err_set = vpp_hi & ~vcc_ok;
    err_d   = err_q;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign seq_err = err_q;
endmodule

// File: rtl/uvrom_core_chk.sv
module uvrom_core_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_s,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_vpp_n,
  input logic              vpp_hi,
  input logic              sig_hv,
  input logic              vcc_ok,
  input logic              erase,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              seq_err
);
  logic rd_now;
  assign rd_now = !ce_n && !vpp_hi && !oe_vpp_n && !sig_hv;

  // R2
  no_bit_rise_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_now && $past(rd_now) && addr == $past(addr) && !$past(erase))
      |-> ((dout & ~$past(dout)) == 8'h00));

  // R6
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ce_n |-> (!dout_en && dout == 8'h00));

  // R7
  vpp_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    vpp_hi |-> !dout_en);

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!ce_n && !vpp_hi && oe_vpp_n) |-> !dout_en);

  // R8
  ident_code_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!ce_n && !vpp_hi && !oe_vpp_n && sig_hv)
      |-> (dout_en && dout == (addr[0] ? 8'h3D : 8'h20)));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (vpp_hi && !vcc_ok) |=> seq_err);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    seq_err |=> seq_err);
endmodule

bind uvrom_core uvrom_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .addr     (addr),
  .ce_n     (ce_n),
  .oe_vpp_n (oe_vpp_n),
  .vpp_hi   (vpp_hi),
  .sig_hv   (sig_hv),
  .vcc_ok   (vcc_ok),
  .erase    (erase),
  .dout     (dout),
  .dout_en  (dout_en),
  .seq_err  (seq_err)
);

// File: tb/uvrom_core_bench.sv
`timescale 1ns/1ps
module uvrom_core_bench;
  localparam int AW = 10;
  localparam logic [AW-1:0] TOP_A = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, oe_vpp_n, vpp_hi, sig_hv, vcc_ok, erase;
  logic [7:0]    din, dout;
  logic          dout_en, seq_err;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  uvrom_core #(.ADDR_W(AW)) u_uvrom_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_vpp_n(oe_vpp_n),
    .vpp_hi(vpp_hi), .sig_hv(sig_hv), .vcc_ok(vcc_ok), .din(din), .erase(erase),
    .dout(dout), .dout_en(dout_en), .seq_err(seq_err)
  );

  typedef struct packed {
    logic          ce_n;
    logic          oe_n;
    logic          vpp;
    logic          sig;
    logic [AW-1:0] a;
    logic          en;
    logic [7:0]    d;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 10'd5,   1'b1, 8'hFF},  // R4 read erased
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd5,   1'b0, 8'h00},  // R5 disable
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd5,   1'b0, 8'h00},  // R6 standby
    '{1'b1, 1'b0, 1'b0, 1'b0, 10'd5,   1'b0, 8'h00},  // R6 standby oe low
    '{1'b1, 1'b0, 1'b0, 1'b1, 10'd0,   1'b0, 8'h00},  // R6 standby sig
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd5,   1'b0, 8'h00},  // R7 inhibit
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd5,   1'b0, 8'h00},  // R7 program mode
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'd0,   1'b1, 8'h20},  // R8 maker
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'd1,   1'b1, 8'h3D},  // R8 device
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd1,   1'b0, 8'h00}   // R5 ident, oe high
  };

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_vpp_n = 1'b1; vpp_hi = 1'b0; sig_hv = 1'b0; erase = 1'b0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [8:0] res);
    @(negedge clk);
    ce_n = 1'b0; oe_vpp_n = 1'b0; vpp_hi = 1'b0; sig_hv = 1'b0; addr = a;
    #2 res = {dout_en, dout};
  endtask

  task automatic program_at(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b1; oe_vpp_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    vpp_hi = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0] r;
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_vpp_n = 1'b1; vpp_hi = 1'b0;
    sig_hv = 1'b0; vcc_ok = 1'b1; din = 8'h00; erase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state: outputs released, no fault
    #2 check("R6 reset outputs", {dout_en, dout}, 9'h000);
    check("R9 reset seq_err", {8'h00, seq_err}, 9'h000);
    // R1 erased after reset
    read_at(10'd0, r);   check("R1 reset byte 0", r, 9'h1FF);
    read_at(TOP_A, r);   check("R1 reset top byte", r, 9'h1FF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ce_n = VECS[i].ce_n; oe_vpp_n = VECS[i].oe_n; vpp_hi = VECS[i].vpp;
      sig_hv = VECS[i].sig; addr = VECS[i].a;
      #2 check($sformatf("R4-R8 vector %0d", i), {dout_en, dout}, {VECS[i].en, VECS[i].d});
    end
    idle();

    // R2 AND update, no 0->1
    program_at(10'd3, 8'hA5);
    read_at(10'd3, r);  check("R2 first program", r, 9'h1A5);
    program_at(10'd3, 8'h0F);
    read_at(10'd3, r);  check("R2 AND with old", r, 9'h105);
    program_at(10'd3, 8'hFF);
    read_at(10'd3, r);  check("R2 no bit set", r, 9'h105);
    read_at(10'd4, r);  check("R2 neighbour untouched", r, 9'h1FF);
    program_at(TOP_A, 8'h5A);
    read_at(TOP_A, r);  check("R2 top address", r, 9'h15A);

    // R3 pulse loses vpp midway, output enable low
    idle();
    @(negedge clk); vpp_hi = 1'b1; addr = 10'd7; din = 8'h00;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); vpp_hi = 1'b0; oe_vpp_n = 1'b0;
    @(negedge clk); vpp_hi = 1'b1; oe_vpp_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); vpp_hi = 1'b0;
    read_at(10'd7, r);  check("R3 aborted pulse", r, 9'h1FF);

    // R7 inhibit: sweep address and data with ce_n high
    idle();
    @(negedge clk); vpp_hi = 1'b1;
    for (int k = 8; k < 12; k++) begin
      @(negedge clk); addr = k[AW-1:0]; din = 8'h00;
      #1 check("R7 inhibit outputs", {dout_en, dout}, 9'h000);
    end
    @(negedge clk); vpp_hi = 1'b0;
    read_at(10'd9, r);  check("R7 inhibit no write", r, 9'h1FF);

    // R1 erase
    idle();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    read_at(10'd3, r);  check("R1 erase restores", r, 9'h1FF);
    read_at(TOP_A, r);  check("R1 erase top", r, 9'h1FF);

    // R9 sequence fault
    idle();
    @(negedge clk); vcc_ok = 1'b0; vpp_hi = 1'b1;
    #1 check("R9 not yet set", {8'h00, seq_err}, 9'h000);
    @(negedge clk); vcc_ok = 1'b1; vpp_hi = 1'b0;
    #1 check("R9 set", {8'h00, seq_err}, 9'h001);
    repeat (3) @(negedge clk);
    #1 check("R9 sticky", {8'h00, seq_err}, 9'h001);

    done = 1;
    summary();
    $finish;
  end
endmodule